// File: doc/BRIEF.md
# Dual-Width Decimal-Capable Accumulator ALU

This block is the arithmetic and logic stage of an accumulator datapath. It is purely combinational. Each evaluation takes the current register value (the accumulator, or an index register for compares), an operand, an operation code and the processor's carry, decimal and width flags. It returns the value to be written back and new N, V, Z and C flag values. It also returns one write enable for the register and a four-bit enable vector that tells the flag register which flags to take.

Add-with-carry and subtract-with-borrow work either in two's-complement binary or in packed BCD. BCD correction runs from the lowest four-bit digit upward, over two digits in byte mode or four in word mode. In byte mode only the low byte of the register is replaced, and the high byte passes through unchanged. Logic operations and load touch only N and Z. Compare and bit-test only set flags.

Top module: `alu_accum`

## Requirements
- R1: Operation code 0 (add) with the decimal flag clear gives result = reg + operand + carry_in, truncated to the active width (8 bits when `wide`=0, 16 bits when `wide`=1). C is the carry out of the active width. flag_we is 4'b1111 and result_we is 1.
- R2: For the add, V is 1 exactly when reg and operand have the same sign bit at the active width and the result's sign bit differs from it.
- R3: Operation code 1 (subtract) with the decimal flag clear gives result = reg − operand + carry_in − 1. C is 1 when that value is not negative. V is 1 when reg and operand differ in sign and reg and the result also differ in sign. flag_we is 4'b1111.
- R4: Add with the decimal flag set works on 4-bit digits, lowest first. Each digit adds the carry from the digit below. A digit sum above 9 is reduced by 10, kept to 4 bits, and carries 1 upward. C is the carry out of digit 1 in byte mode or digit 3 in word mode. V follows the R2 rule on the corrected result.
- R5: Subtract with the decimal flag set takes each digit of the operand from the register's digit. The lowest digit also takes the inverted carry_in. A digit that goes below zero gets 10 added, is kept to 4 bits, and borrows 1 from the next digit. C is 0 if the top active digit borrows and 1 otherwise. V follows the R3 rule.
- R6: When `wide`=0 and result_we is 1, result[15:8] equals reg_in[15:8].
- R7: Whenever the N or Z flag is enabled, N is the sign bit of the flag source at the active width and Z is 1 when that source is zero at the active width. The flag source is the result for codes 0, 1 and 4–7 and the difference for code 2.
- R8: Codes 4, 5, 6 and 7 give AND, OR, XOR and load (result = operand). For these codes result_we is 1 and flag_we is 4'b1010, so only N and Z update. In flag_we, bit 3 is N, bit 2 is V, bit 1 is Z and bit 0 is C.
- R9: Code 2 (compare) gives result_we = 0 and result = reg_in, and flag_we is 4'b1011. C is 1 when reg ≥ operand (unsigned, active width). N and Z come from reg − operand. The decimal flag has no effect.
- R10: Code 3 (bit-test) gives result_we = 0 and result = reg_in, and flag_we is 4'b1110. V is operand bit 14 (bit 6 in byte mode). N is the operand's top active bit. Z is 1 when (reg AND operand) is zero at the active width.
- R11: Codes 8 to 15 give result = reg_in, result_we = 0 and flag_we = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_in | input | 16 | Current value of the selected register |
| operand | input | 16 | Second operand |
| op | input | 4 | Operation code |
| carry_in | input | 1 | Current carry flag |
| decimal | input | 1 | 1 selects BCD add/subtract |
| wide | input | 1 | 1 = 16-bit mode, 0 = 8-bit mode |
| result | output | 16 | Value to write back to the register |
| result_we | output | 1 | Register write enable |
| n_out | output | 1 | New N flag |
| v_out | output | 1 | New V flag |
| z_out | output | 1 | New Z flag |
| c_out | output | 1 | New C flag |
| flag_we | output | 4 | Flag enables {N, V, Z, C} |

## Verification
No register lies between any input and any output, so every output is due in the same cycle its stimulus is applied, including the BCD carry that ripples through all four digits. The bench changes inputs one step after a rising edge. It compares against its reference model at the following falling edge, half a period later, when the whole digit chain has settled and before the next change. A flag is compared only when its enable is expected high. The enable vector itself is always compared, so a flag that should be held is still checked.

// File: rtl/alu_accum_pkg.sv
package alu_accum_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_BTST = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_LOAD = 4'd7
  } alu_op_e;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_V = 2;
  localparam int FLG_N = 3;

  localparam logic [3:0] FWE_ALL   = 4'b1111;
  localparam logic [3:0] FWE_NZ    = 4'b1010;
  localparam logic [3:0] FWE_NZC   = 4'b1011;
  localparam logic [3:0] FWE_NVZ   = 4'b1110;
  localparam logic [3:0] FWE_NONE  = 4'b0000;

endpackage

// File: rtl/alu_bcd_chain.sv
module alu_bcd_chain #(
  parameter int NIB_W         = 4,
  parameter int DIGITS        = 4,
  parameter int NARROW_DIGITS = 2
) (
  input  logic [NIB_W*DIGITS-1:0] a_in,
  input  logic [NIB_W*DIGITS-1:0] b_in,
  input  logic                    sub_mode,
  input  logic                    link_in,
  output logic [NIB_W*DIGITS-1:0] dec_out,
  output logic                    link_narrow,
  output logic                    link_wide
);

  localparam logic [NIB_W-1:0] TEN  = NIB_W'(10);
  localparam logic [NIB_W:0]   NINE = (NIB_W+1)'(9);

  // link[i] is the carry (add) or borrow (subtract) entering digit i
  logic [DIGITS:0] link;
  assign link[0] = link_in;

  genvar gi;
  generate
    for (gi = 0; gi < DIGITS; gi++) begin : g_digit
      logic [NIB_W-1:0] da;
      logic [NIB_W-1:0] db;
      logic [NIB_W:0]   t_add;
      logic [NIB_W:0]   t_sub;
      logic             add_fix;
      logic             sub_fix;
      logic [NIB_W-1:0] add_dig;
      logic [NIB_W-1:0] sub_dig;

      assign da      = a_in[gi*NIB_W +: NIB_W];
      assign db      = b_in[gi*NIB_W +: NIB_W];
      assign t_add   = {1'b0, da} + {1'b0, db} + {{NIB_W{1'b0}}, link[gi]};
      assign t_sub   = {1'b0, da} - {1'b0, db} - {{NIB_W{1'b0}}, link[gi]};
      assign add_fix = t_add > NINE;
      assign sub_fix = t_sub[NIB_W];
      assign add_dig = add_fix ? (t_add[NIB_W-1:0] - TEN) : t_add[NIB_W-1:0];
      assign sub_dig = sub_fix ? (t_sub[NIB_W-1:0] + TEN) : t_sub[NIB_W-1:0];

      assign dec_out[gi*NIB_W +: NIB_W] = sub_mode ? sub_dig : add_dig;
      assign link[gi+1]                 = sub_mode ? sub_fix : add_fix;
    end
  endgenerate

  assign link_narrow = link[NARROW_DIGITS];
  assign link_wide   = link[DIGITS];

endmodule

// File: rtl/alu_bin_addsub.sv
module alu_bin_addsub #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              sub_mode,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              c_wide,
  output logic              c_narrow
);

  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   full;

  assign b_eff    = sub_mode ? ~b_in : b_in;
  assign full     = {1'b0, a_in} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
  assign sum      = full[DATA_W-1:0];
  assign c_wide   = full[DATA_W];
  // carry into bit HALF recovered from that bit's sum
  assign c_narrow = a_in[HALF] ^ b_eff[HALF] ^ full[HALF];

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [1:0]        sel,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    unique case (sel)
      2'd0:    y = a_in & b_in;
      2'd1:    y = a_in | b_in;
      2'd2:    y = a_in ^ b_in;
      default: y = b_in;
    endcase
  end

endmodule

// File: rtl/alu_accum.sv
module alu_accum
  import alu_accum_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] reg_in,
  input  logic [DATA_W-1:0] operand,
  input  logic [OP_W-1:0]   op,
  input  logic              carry_in,
  input  logic              decimal,
  input  logic              wide,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic              n_out,
  output logic              v_out,
  output logic              z_out,
  output logic              c_out,
  output logic [3:0]        flag_we
);

  localparam int HALF     = DATA_W / 2;
  localparam int DIGITS   = DATA_W / NIB_W;
  localparam int DIGITS_N = HALF / NIB_W;

  function automatic logic sign_at(input logic [DATA_W-1:0] x, input logic w);
    return w ? x[DATA_W-1] : x[HALF-1];
  endfunction

  function automatic logic zero_at(input logic [DATA_W-1:0] x, input logic w);
    return w ? (x == '0) : (x[HALF-1:0] == '0);
  endfunction

  function automatic logic bit_below_sign(input logic [DATA_W-1:0] x, input logic w);
    return w ? x[DATA_W-2] : x[HALF-2];
  endfunction

  // decode
  logic is_add, is_sub, is_cmp, is_logic, use_bcd;
  assign is_add   = (op == OP_ADD);
  assign is_sub   = (op == OP_SUB);
  assign is_cmp   = (op == OP_CMP);
  assign is_logic = (op[3:2] == 2'b01);
  assign use_bcd  = decimal & (is_add | is_sub);

  // binary adder, shared by add, subtract and compare
  logic [DATA_W-1:0] bin_sum;
  logic              bin_c_wide, bin_c_narrow, bin_carry;

  alu_bin_addsub #(.DATA_W(DATA_W)) u_bin (
    .a_in     (reg_in),
    .b_in     (operand),
    .sub_mode (~is_add),
    .cin      (is_cmp | carry_in),
    .sum      (bin_sum),
    .c_wide   (bin_c_wide),
    .c_narrow (bin_c_narrow)
  );
  assign bin_carry = wide ? bin_c_wide : bin_c_narrow;

  // digit-serial decimal path
  logic [DATA_W-1:0] bcd_sum;
  logic              bcd_link_n, bcd_link_w, bcd_link, bcd_carry;

  alu_bcd_chain #(
    .NIB_W         (NIB_W),
    .DIGITS        (DIGITS),
    .NARROW_DIGITS (DIGITS_N)
  ) u_bcd (
    .a_in        (reg_in),
    .b_in        (operand),
    .sub_mode    (is_sub),
    .link_in     (is_sub ? ~carry_in : carry_in),
    .dec_out     (bcd_sum),
    .link_narrow (bcd_link_n),
    .link_wide   (bcd_link_w)
  );
  assign bcd_link  = wide ? bcd_link_w : bcd_link_n;
  assign bcd_carry = is_sub ? ~bcd_link : bcd_link;

  // logic unit
  logic [DATA_W-1:0] logic_val;

  alu_bitwise #(.DATA_W(DATA_W)) u_logic (
    .a_in (reg_in),
    .b_in (operand),
    .sel  (op[1:0]),
    .y    (logic_val)
  );

  // arithmetic result and its overflow
  logic [DATA_W-1:0] arith_val;
  logic              arith_carry, add_ovf, sub_ovf;

  assign arith_val   = use_bcd ? bcd_sum : bin_sum;
  assign arith_carry = use_bcd ? bcd_carry : bin_carry;
  assign add_ovf     = sign_at(~(reg_in ^ operand) & (operand ^ arith_val), wide);
  assign sub_ovf     = sign_at((reg_in ^ operand) & (reg_in ^ arith_val), wide);

  // per-operation selection
  logic [DATA_W-1:0] new_val;

  always_comb begin
    new_val   = reg_in;
    result_we = 1'b0;
    flag_we   = FWE_NONE;
    n_out     = 1'b0;
    v_out     = 1'b0;
    z_out     = 1'b0;
    c_out     = 1'b0;
    if (is_add || is_sub) begin
      new_val   = arith_val;
      result_we = 1'b1;
      flag_we   = FWE_ALL;
      n_out     = sign_at(arith_val, wide);
      z_out     = zero_at(arith_val, wide);
      v_out     = is_add ? add_ovf : sub_ovf;
      c_out     = arith_carry;
    end else if (is_logic) begin
      new_val   = logic_val;
      result_we = 1'b1;
      flag_we   = FWE_NZ;
      n_out     = sign_at(logic_val, wide);
      z_out     = zero_at(logic_val, wide);
    end else if (is_cmp) begin
      flag_we   = FWE_NZC;
      n_out     = sign_at(bin_sum, wide);
      z_out     = zero_at(bin_sum, wide);
      c_out     = bin_carry;
    end else if (op == OP_BTST) begin
      flag_we   = FWE_NVZ;
      n_out     = sign_at(operand, wide);
      v_out     = bit_below_sign(operand, wide);
      z_out     = zero_at(reg_in & operand, wide);
    end
  end

  assign result = wide ? new_val : {reg_in[DATA_W-1:HALF], new_val[HALF-1:0]};

endmodule

// File: rtl/alu_accum_chk.sv
module alu_accum_chk
  import alu_accum_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4
) (
  input logic [DATA_W-1:0] reg_in,
  input logic [DATA_W-1:0] operand,
  input logic [OP_W-1:0]   op,
  input logic              carry_in,
  input logic              decimal,
  input logic              wide,
  input logic [DATA_W-1:0] result,
  input logic              result_we,
  input logic              n_out,
  input logic              v_out,
  input logic              z_out,
  input logic              c_out,
  input logic [3:0]        flag_we
);

  localparam int HALF     = DATA_W / 2;
  localparam int DIGITS   = DATA_W / NIB_W;
  localparam int DIGITS_N = HALF / NIB_W;

  function automatic logic [DATA_W-1:0] active(input logic [DATA_W-1:0] x, input logic w);
    return w ? x : {{HALF{1'b0}}, x[HALF-1:0]};
  endfunction

  function automatic logic top_bit(input logic [DATA_W-1:0] x, input logic w);
    return w ? x[DATA_W-1] : x[HALF-1];
  endfunction

  function automatic logic digits_valid(input logic [DATA_W-1:0] x, input logic w);
    logic ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if ((w || i < DIGITS_N) && (x[i*NIB_W +: NIB_W] > NIB_W'(9))) ok = 1'b0;
    end
    return ok;
  endfunction

  always_comb begin
    if (!wide && result_we)
      assert_narrow_keeps_high_R6: assert (result[DATA_W-1:HALF] == reg_in[DATA_W-1:HALF])
        else $error("high byte changed in byte mode");

    if (result_we && flag_we[FLG_Z])
      assert_zero_tracks_result_R7: assert (z_out == (active(result, wide) == '0))
        else $error("Z disagrees with written result");

    if (result_we && flag_we[FLG_N])
      assert_sign_tracks_result_R7: assert (n_out == top_bit(result, wide))
        else $error("N disagrees with written result");

    if (op[3:2] == 2'b01)
      assert_logic_flag_mask_R8: assert (result_we && flag_we == FWE_NZ)
        else $error("logic op enables wrong flags");

    if (op == OP_CMP)
      assert_compare_no_write_R9: assert (!result_we && result == reg_in && flag_we == FWE_NZC
                                          && c_out == (active(reg_in, wide) >= active(operand, wide)))
        else $error("compare misbehaves");

    if (op == OP_BTST)
      assert_bittest_flags_R10: assert (!result_we && result == reg_in
                                        && v_out == (wide ? operand[DATA_W-2] : operand[HALF-2])
                                        && n_out == top_bit(operand, wide))
        else $error("bit-test misbehaves");

    if (op[3])
      assert_unused_code_idle_R11: assert (!result_we && flag_we == FWE_NONE && result == reg_in)
        else $error("unused code has an effect");

    if (op == OP_ADD && decimal && digits_valid(reg_in, wide) && digits_valid(operand, wide))
      assert_bcd_digits_valid_R4: assert (digits_valid(result, wide))
        else $error("decimal add left a digit above 9");

    if (op == OP_ADD && !decimal && !carry_in && active(operand, wide) == '0)
      assert_add_zero_identity_R1: assert (active(result, wide) == active(reg_in, wide) && !c_out)
        else $error("adding zero changed the value");
  end

endmodule

bind alu_accum alu_accum_chk #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_alu_accum_chk (
  .reg_in    (reg_in),
  .operand   (operand),
  .op        (op),
  .carry_in  (carry_in),
  .decimal   (decimal),
  .wide      (wide),
  .result    (result),
  .result_we (result_we),
  .n_out     (n_out),
  .v_out     (v_out),
  .z_out     (z_out),
  .c_out     (c_out),
  .flag_we   (flag_we)
);

// File: tb/tb_alu_accum.sv
module tb_alu_accum;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] reg_in = '0, operand = '0;
  logic [3:0]  op = 4'd8;
  logic        carry_in = 1'b0, decimal = 1'b0, wide = 1'b0;
  logic [15:0] result;
  logic        result_we, n_out, v_out, z_out, c_out;
  logic [3:0]  flag_we;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  alu_accum dut (
    .reg_in(reg_in), .operand(operand), .op(op), .carry_in(carry_in),
    .decimal(decimal), .wide(wide), .result(result), .result_we(result_we),
    .n_out(n_out), .v_out(v_out), .z_out(z_out), .c_out(c_out), .flag_we(flag_we)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (op=%0d reg=%h opnd=%h c=%0b d=%0b w=%0b)",
               tag, what, act, exp, op, reg_in, operand, carry_in, decimal, wide);
    end
  endtask

  function automatic string op_tag(input int o, input bit d);
    case (o)
      0:       return d ? "R4" : "R1";
      1:       return d ? "R5" : "R3";
      2:       return "R9";
      3:       return "R10";
      4, 5, 6, 7: return "R8";
      default: return "R11";
    endcase
  endfunction

  // behavioural reference built from the requirement text
  task automatic model(input int r, input int b, input int o, input int c, input int d, input int w,
                       output int er, output int ewe, output int efw,
                       output int en, output int ev, output int ez, output int ec);
    int width = w ? 16 : 8;
    int mask  = (1 << width) - 1;
    int a     = r & mask;
    int bb    = b & mask;
    int sgn   = width - 1;
    int val   = 0;
    int link;
    int dig;
    er = r; ewe = 0; efw = 0; en = 0; ev = 0; ez = 0; ec = 0;
    if (o == 0 || o == 1) begin
      if (d != 0) begin
        link = (o == 0) ? c : 1 - c;
        for (int i = 0; i < width / 4; i++) begin
          if (o == 0) begin
            dig = ((a >> (4*i)) & 15) + ((bb >> (4*i)) & 15) + link;
            if (dig > 9) begin dig = (dig - 10) & 15; link = 1; end else link = 0;
          end else begin
            dig = ((a >> (4*i)) & 15) - ((bb >> (4*i)) & 15) - link;
            if (dig < 0) begin dig = (dig + 10) & 15; link = 1; end else link = 0;
          end
          val = val | (dig << (4*i));
        end
        ec = (o == 0) ? link : 1 - link;
      end else if (o == 0) begin
        val = a + bb + c;
        ec  = (val > mask) ? 1 : 0;
        val = val & mask;
      end else begin
        val = a - bb + c - 1;
        ec  = (val >= 0) ? 1 : 0;
        val = val & mask;
      end
      if (o == 0) ev = ((~(a ^ bb) & (bb ^ val)) >> sgn) & 1;
      else        ev = (((a ^ bb) & (a ^ val)) >> sgn) & 1;
      ewe = 1; efw = 15;
    end else if (o >= 4 && o <= 7) begin
      case (o)
        4: val = a & bb;
        5: val = a | bb;
        6: val = a ^ bb;
        default: val = bb;
      endcase
      ewe = 1; efw = 10;
    end else if (o == 2) begin
      val = (a - bb) & mask;
      ec  = (a >= bb) ? 1 : 0;
      efw = 11;
    end else if (o == 3) begin
      ev  = (bb >> (width - 2)) & 1;
      en  = (bb >> sgn) & 1;
      ez  = ((a & bb) == 0) ? 1 : 0;
      efw = 14;
    end
    if (o != 3 && o < 8) begin
      en = (val >> sgn) & 1;
      ez = (val == 0) ? 1 : 0;
    end
    if (ewe != 0) er = w ? val : ((r & 16'hFF00) | val);
  endtask

  task automatic run_vec(input int r, input int b, input int o, input int c, input int d, input int w);
    int er, ewe, efw, en, ev, ez, ec;
    string t;
    @(posedge clk);
    #1;
    reg_in = 16'(r); operand = 16'(b); op = 4'(o);
    carry_in = c[0]; decimal = d[0]; wide = w[0];
    model(r, b, o, c, d, w, er, ewe, efw, en, ev, ez, ec);
    t = op_tag(o, d != 0);
    @(negedge clk);
    check(t, "result", int'(result), er);
    if (w == 0 && ewe != 0) check("R6", "high byte", int'(result[15:8]), (r >> 8) & 255);
    check(t, "result_we", int'(result_we), ewe);
    check(t, "flag_we", int'(flag_we), efw);
    if (efw[3]) check("R7", "N", int'(n_out), en);
    if (efw[2]) check((o == 0 && d == 0) ? "R2" : t, "V", int'(v_out), ev);
    if (efw[1]) check("R7", "Z", int'(z_out), ez);
    if (efw[0]) check(t, "C", int'(c_out), ec);
  endtask

  function automatic int rand_bcd();
    int v = 0;
    for (int i = 0; i < 4; i++) v = v | (int'($urandom % 10) << (4*i));
    return v;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle state after reset: unused code, everything quiet (R11)
    @(negedge clk);
    check("R11", "idle result", int'(result), 0);
    check("R11", "idle flag_we", int'(flag_we), 0);
    check("R11", "idle result_we", int'(result_we), 0);

    // R1 / R2 binary add corners
    run_vec(16'hAB7F, 16'h0001, 0, 0, 0, 0);  // 0x80, V set
    run_vec(16'h12FF, 16'h0001, 0, 0, 0, 0);  // wraps to 0, C set
    run_vec(16'hFFFF, 16'h0000, 0, 1, 0, 1);
    run_vec(16'h8000, 16'h8000, 0, 0, 0, 1);  // negative overflow
    // R3 binary subtract
    run_vec(16'h0080, 16'h0001, 1, 1, 0, 0);  // 0x7F, V set
    run_vec(16'h0000, 16'h0001, 1, 1, 0, 1);  // borrow
    run_vec(16'h0005, 16'h0005, 1, 0, 0, 1);
    // R4 decimal add
    run_vec(16'h5599, 16'h0001, 0, 0, 1, 0);  // 00, C
    run_vec(16'h9999, 16'h0001, 0, 0, 1, 1);
    run_vec(16'h0058, 16'h0046, 0, 1, 1, 1);  // 0105
    run_vec(16'h0049, 16'h0049, 0, 0, 1, 0);  // 98, V
    // R5 decimal subtract
    run_vec(16'h3300, 16'h0001, 1, 1, 1, 0);  // 99, C clear
    run_vec(16'h1000, 16'h0001, 1, 1, 1, 1);  // 0999
    run_vec(16'h0000, 16'h0000, 1, 0, 1, 1);  // 9999
    // R8 logic and load
    run_vec(16'hF0F0, 16'h0FF0, 4, 1, 0, 1);
    run_vec(16'hAA00, 16'h0080, 5, 0, 0, 0);
    run_vec(16'h00FF, 16'h00FF, 6, 0, 0, 0);
    run_vec(16'h1234, 16'h0000, 7, 1, 1, 1);
    // R9 compare
    run_vec(16'h0040, 16'h0040, 2, 0, 1, 0);
    run_vec(16'h0003, 16'h0004, 2, 1, 0, 1);
    run_vec(16'hFF10, 16'h0020, 2, 0, 0, 0);
    // R10 bit-test
    run_vec(16'h0001, 16'h00C0, 3, 0, 0, 0);
    run_vec(16'hFFFF, 16'h4000, 3, 1, 0, 1);
    // R11 unused codes
    for (int k = 8; k < 16; k++) run_vec(16'h5A5A, 16'hFFFF, k, 1, 1, k & 1);

    // broad sweep
    for (int n = 0; n < 4000; n++) begin
      int o = int'($urandom % 16);
      int d = int'($urandom % 2);
      int r, b;
      if (d != 0 && ($urandom % 4) != 0) begin
        r = rand_bcd(); b = rand_bcd();
      end else begin
        r = int'($urandom & 32'hFFFF); b = int'($urandom & 32'hFFFF);
      end
      run_vec(r, b, o, int'($urandom % 2), d, int'($urandom % 2));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule